// File: doc/BRIEF.md
# Dual-ADC Staggered Conversion Scheduler

This block schedules conversions on two converter cores, a master and a slave, each seen as a simple start/done handshake. When the combined mode is selected, one regular trigger on the master launches a regular conversion on both cores, with the second start a fixed number of clock cycles after the first. A preempted trigger on the master starts preempted conversions on both cores in the same cycle. If a staggered regular pair is in flight at that moment, it is cut short. Once both preempted conversions are done, the pair is relaunched with the slave going first.

When the mode field holds any other code, the two cores are scheduled on their own. Each core takes its own regular and preempted trigger inputs, and a preempted trigger still aborts that core's own regular conversion. Every start strobe comes with a group tag. Each core keeps sticky completion flags, one per group, which software clears by writing ones.

Top module: `dual_adc_sched`

## Requirements
- R1: After reset all start strobes, abort strobes and completion flags are low, and the scheduler is idle.
- R2: In combined mode (mode field equal to COMB_CODE, default 6), a regular trigger on the master gives a master start with group tag 0 (regular) one cycle later. The slave regular start follows exactly STAGGER (default 14) cycles after the master start, and the two regular starts never fall in the same cycle.
- R3: In combined mode, a preempted trigger on the master gives master and slave starts in the same cycle one cycle later, both with group tag 1 (preempted).
- R4: A preempted trigger during a staggered regular pair raises the abort strobe of every core that is busy with a regular conversion, in the same cycle as the preempted starts. A regular start still owed to the other core is cancelled, and an aborted conversion sets no flag.
- R5: When both preempted conversions that interrupted a pair have completed, the pair is relaunched with the slave regular start first, one cycle after the last done. The master regular start follows STAGGER cycles later.
- R6: A preempted trigger that arrives while preempted conversions are active is ignored and produces no start.
- R7: A regular trigger that arrives during preempted conversions is held and launches a master-first pair one cycle after the last preempted done. A regular trigger during a regular pair is ignored.
- R8: Each core sets its own completion flag for the group of its conversion (bit 0 master, bit 1 slave) in the cycle after its done input, independently of the other core. A done input on an idle core is ignored.
- R9: Completion flags stay set until a one is written to the matching clear bit. A set and a clear on the same bit in the same cycle leave the flag set.
- R10: With any other mode code, the master obeys only the master triggers and the slave only the slave triggers. In combined mode the slave trigger inputs are ignored. The mode field is taken only while both cores are idle and no trigger is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | MODE_W | Mode field; COMB_CODE selects combined mode |
| reg_trig_m | input | 1 | Master regular trigger |
| pre_trig_m | input | 1 | Master preempted trigger |
| reg_trig_s | input | 1 | Slave regular trigger (independent mode only) |
| pre_trig_s | input | 1 | Slave preempted trigger (independent mode only) |
| done_m | input | 1 | Master conversion done |
| done_s | input | 1 | Slave conversion done |
| clr_reg | input | 2 | Write-one-to-clear for regular flags (bit 0 master, bit 1 slave) |
| clr_pre | input | 2 | Write-one-to-clear for preempted flags |
| start_m | output | 1 | Master start strobe |
| start_s | output | 1 | Slave start strobe |
| grp_m | output | 1 | Master group tag (0 regular, 1 preempted) |
| grp_s | output | 1 | Slave group tag |
| abort_m | output | 1 | Master abort strobe |
| abort_s | output | 1 | Slave abort strobe |
| cmpl_reg | output | 2 | Sticky regular completion flags |
| cmpl_pre | output | 2 | Sticky preempted completion flags |

## Verification
A fault in the stagger counter shows up as a slave start arriving earlier or later than STAGGER cycles after the master start, and the gap is visible within that same window. A wrong sequencer state after a preemption shows up at the first start that follows the last preempted done. It appears there either as the wrong core going first or as a start that is missing or extra. Faulty per-core busy or flag state shows up as a flag that does not rise one cycle after a done, or as a flag that drops without a clear. An abort without its preempted start also reveals faulty busy state, and each of these is visible on the cycle in question.

// File: rtl/dual_adc_pkg.sv
package dual_adc_pkg;
  localparam int NCORE  = 2;
  localparam int CORE_M = 0;
  localparam int CORE_S = 1;

  localparam logic GRP_REG = 1'b0;
  localparam logic GRP_PRE = 1'b1;

  typedef enum logic [1:0] {
    SCH_IDLE = 2'd0,
    SCH_REG  = 2'd1,
    SCH_PRE  = 2'd2
  } sch_state_e;

  // Sticky flag update: set wins over clear.
  function automatic logic [NCORE-1:0] flag_next(input logic [NCORE-1:0] cur,
                                                 input logic [NCORE-1:0] set,
                                                 input logic [NCORE-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // Stagger reached: counter holds cycles since the first start plus one.
  function automatic logic stagger_due(input int unsigned cnt, input int unsigned limit);
    return cnt == limit;
  endfunction
endpackage

// File: rtl/dual_adc_stagger_timer.sv
module dual_adc_stagger_timer #(
  parameter int STAGGER = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cancel_i,
  output logic active_o,
  output logic fire_o
);
  import dual_adc_pkg::*;
  localparam int CW = $clog2(STAGGER + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign active_o = active_q;
  assign fire_o   = active_q && stagger_due(int'(cnt_q), STAGGER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= CW'(1);
      active_q <= 1'b1;
    end else if (cancel_i || fire_o) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/dual_adc_lane.sv
module dual_adc_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic launch_grp_i,
  input  logic abort_i,
  input  logic done_i,
  output logic start_o,
  output logic abort_o,
  output logic grp_o,
  output logic busy_o,
  output logic fin_reg_o,
  output logic fin_pre_o
);
  import dual_adc_pkg::*;

  logic busy_q;
  logic grp_q;
  logic fin;

  // A done in a cycle where the conversion is being replaced belongs to the old one.
  assign fin       = done_i && busy_q && !abort_i && !launch_i;
  assign fin_reg_o = fin && (grp_q == GRP_REG);
  assign fin_pre_o = fin && (grp_q == GRP_PRE);
  assign busy_o    = busy_q;
  assign grp_o     = grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grp_q   <= GRP_REG;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= launch_i;
      abort_o <= abort_i && busy_q;
      if (launch_i) begin
        busy_q <= 1'b1;
        grp_q  <= launch_grp_i;
      end else if (abort_i || fin) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_adc_flags.sv
module dual_adc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_reg_i,
  input  logic [N-1:0] set_pre_i,
  input  logic [N-1:0] clr_reg_i,
  input  logic [N-1:0] clr_pre_i,
  output logic [N-1:0] flag_reg_o,
  output logic [N-1:0] flag_pre_o
);
  import dual_adc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_reg_o <= '0;
      flag_pre_o <= '0;
    end else begin
      flag_reg_o <= flag_next(flag_reg_o, set_reg_i, clr_reg_i);
      flag_pre_o <= flag_next(flag_pre_o, set_pre_i, clr_pre_i);
    end
  end
endmodule

// File: rtl/dual_adc_sched.sv
module dual_adc_sched #(
  parameter int              STAGGER   = 14,
  parameter int              MODE_W    = 4,
  parameter logic [MODE_W-1:0] COMB_CODE = 4'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              reg_trig_m,
  input  logic              pre_trig_m,
  input  logic              reg_trig_s,
  input  logic              pre_trig_s,
  input  logic              done_m,
  input  logic              done_s,
  input  logic [1:0]        clr_reg,
  input  logic [1:0]        clr_pre,
  output logic              start_m,
  output logic              start_s,
  output logic              grp_m,
  output logic              grp_s,
  output logic              abort_m,
  output logic              abort_s,
  output logic [1:0]        cmpl_reg,
  output logic [1:0]        cmpl_pre
);
  import dual_adc_pkg::*;

  // Per-core vectors: bit CORE_M master, bit CORE_S slave.
  logic [NCORE-1:0] launch, lgrp, abrt;
  logic [NCORE-1:0] busy, bgrp, fin_reg, fin_pre;
  logic [NCORE-1:0] start_v, abort_v, grp_v;
  logic [NCORE-1:0] done_v, rtrig_v, ptrig_v;

  assign done_v  = {done_s, done_m};
  assign rtrig_v = {reg_trig_s, reg_trig_m};
  assign ptrig_v = {pre_trig_s, pre_trig_m};

  // Mode register, sampled only when nothing is running.
  logic mode_q;
  logic comb_active;
  logic all_idle;
  logic any_trig;

  // Combined sequencer state.
  sch_state_e state_q, state_d;
  logic first_q, first_d;      // core index that started the pair first
  logic resume_q, resume_d;    // an interrupted pair must be relaunched
  logic latch_q, latch_d;      // regular trigger held during preempted work

  logic t_load, t_cancel, t_active, t_fire;

  // Named internal events for the checker.
  logic pre_launch;
  logic resume_launch;
  logic stag_fire;

  logic [NCORE-1:0] c_launch, c_grp, c_abort;
  logic [NCORE-1:0] i_launch, i_grp, i_abort;

  assign comb_active = mode_q;
  assign any_trig    = |{rtrig_v, ptrig_v};
  assign all_idle    = (state_q == SCH_IDLE) && (busy == '0) && !t_active;
  assign stag_fire   = t_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (all_idle && !any_trig) mode_q <= (mode_sel == COMB_CODE);
  end

  // Combined-mode sequencer
  always_comb begin
    c_launch      = '0;
    c_grp         = '0;
    c_abort       = '0;
    t_load        = 1'b0;
    t_cancel      = 1'b0;
    state_d       = state_q;
    first_d       = first_q;
    resume_d      = resume_q;
    latch_d       = latch_q;
    pre_launch    = 1'b0;
    resume_launch = 1'b0;
    if (comb_active) begin
      case (state_q)
        SCH_IDLE: begin
          if (pre_trig_m) begin
            c_launch   = '1;
            c_grp      = '1;
            latch_d    = reg_trig_m;
            state_d    = SCH_PRE;
            pre_launch = 1'b1;
          end else if (reg_trig_m) begin
            c_launch[CORE_M] = 1'b1;
            first_d          = 1'b0;
            t_load           = 1'b1;
            state_d          = SCH_REG;
          end
        end
        SCH_REG: begin
          if (pre_trig_m) begin
            c_abort    = busy;
            c_launch   = '1;
            c_grp      = '1;
            t_cancel   = 1'b1;
            resume_d   = 1'b1;
            state_d    = SCH_PRE;
            pre_launch = 1'b1;
          end else if (t_fire) begin
            c_launch[~first_q] = 1'b1;
          end else if (!t_active && (busy == '0)) begin
            state_d = SCH_IDLE;
          end
        end
        SCH_PRE: begin
          if (reg_trig_m) latch_d = 1'b1;
          if (busy == '0) begin
            if (resume_q) begin
              c_launch[CORE_S] = 1'b1;
              first_d          = 1'b1;
              t_load           = 1'b1;
              resume_d         = 1'b0;
              latch_d          = 1'b0;
              state_d          = SCH_REG;
              resume_launch    = 1'b1;
            end else if (latch_q || reg_trig_m) begin
              c_launch[CORE_M] = 1'b1;
              first_d          = 1'b0;
              t_load           = 1'b1;
              latch_d          = 1'b0;
              state_d          = SCH_REG;
            end else begin
              state_d = SCH_IDLE;
            end
          end
        end
        default: state_d = SCH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SCH_IDLE;
      first_q  <= 1'b0;
      resume_q <= 1'b0;
      latch_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      first_q  <= first_d;
      resume_q <= resume_d;
      latch_q  <= latch_d;
    end
  end

  // Independent-mode per-core scheduling
  always_comb begin
    i_launch = '0;
    i_grp    = '0;
    i_abort  = '0;
    if (!comb_active) begin
      for (int c = 0; c < NCORE; c++) begin
        if (ptrig_v[c] && !(busy[c] && (bgrp[c] == GRP_PRE))) begin
          i_launch[c] = 1'b1;
          i_grp[c]    = GRP_PRE;
          i_abort[c]  = busy[c];
        end else if (rtrig_v[c] && !busy[c]) begin
          i_launch[c] = 1'b1;
          i_grp[c]    = GRP_REG;
        end
      end
    end
  end

  assign launch = comb_active ? c_launch : i_launch;
  assign lgrp   = comb_active ? c_grp    : i_grp;
  assign abrt   = comb_active ? c_abort  : i_abort;

  dual_adc_stagger_timer #(.STAGGER(STAGGER)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (t_load),
    .cancel_i (t_cancel),
    .active_o (t_active),
    .fire_o   (t_fire)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_lane
    dual_adc_lane u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_i     (launch[g]),
      .launch_grp_i (lgrp[g]),
      .abort_i      (abrt[g]),
      .done_i       (done_v[g]),
      .start_o      (start_v[g]),
      .abort_o      (abort_v[g]),
      .grp_o        (grp_v[g]),
      .busy_o       (busy[g]),
      .fin_reg_o    (fin_reg[g]),
      .fin_pre_o    (fin_pre[g])
    );
    assign bgrp[g] = grp_v[g];
  end

  dual_adc_flags #(.N(NCORE)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_reg_i  (fin_reg),
    .set_pre_i  (fin_pre),
    .clr_reg_i  (clr_reg),
    .clr_pre_i  (clr_pre),
    .flag_reg_o (cmpl_reg),
    .flag_pre_o (cmpl_pre)
  );

  assign start_m = start_v[CORE_M];
  assign start_s = start_v[CORE_S];
  assign grp_m   = grp_v[CORE_M];
  assign grp_s   = grp_v[CORE_S];
  assign abort_m = abort_v[CORE_M];
  assign abort_s = abort_v[CORE_S];
endmodule

// File: rtl/dual_adc_sched_chk.sv
module dual_adc_sched_chk #(
  parameter int STAGGER = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       comb_active,
  input logic       start_m,
  input logic       start_s,
  input logic       grp_m,
  input logic       grp_s,
  input logic       abort_m,
  input logic       abort_s,
  input logic       done_m,
  input logic       done_s,
  input logic [1:0] clr_reg,
  input logic [1:0] clr_pre,
  input logic [1:0] cmpl_reg,
  input logic [1:0] cmpl_pre
);
  localparam int CW = $clog2(STAGGER + 2);

  logic          reg_start_any, pre_start_any;
  logic          pend_q;
  logic [CW-1:0] gap_q;

  assign reg_start_any = (start_m && !grp_m) || (start_s && !grp_s);
  assign pre_start_any = (start_m && grp_m) || (start_s && grp_s);

  // Independent count of cycles since the first regular start of a pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else if (!comb_active || pre_start_any) begin
      pend_q <= 1'b0;
    end else if (reg_start_any) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        gap_q  <= CW'(1);
      end
    end else if (pend_q && (gap_q != '1)) begin
      gap_q <= gap_q + CW'(1);
    end
  end

  AST_STAGGER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    comb_active && reg_start_any && pend_q |-> gap_q == CW'(STAGGER)); // R2
  AST_NO_TWIN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    comb_active |-> !(start_m && start_s && !grp_m && !grp_s)); // R2
  AST_PRE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    comb_active && start_m && grp_m |-> start_s && grp_s); // R3
  AST_ABORT_M_WITH_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_m |-> start_m && grp_m); // R4
  AST_ABORT_S_WITH_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_s |-> start_s && grp_s); // R4
  AST_FLAG_M_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_reg[0]) || $rose(cmpl_pre[0]) |-> $past(done_m)); // R8
  AST_FLAG_S_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_reg[1]) || $rose(cmpl_pre[1]) |-> $past(done_s)); // R8

  for (genvar b = 0; b < 2; b++) begin : g_sticky
    AST_REG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_reg[b] && !clr_reg[b] |=> cmpl_reg[b]); // R9
    AST_PRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pre[b] && !clr_pre[b] |=> cmpl_pre[b]); // R9
  end
endmodule

bind dual_adc_sched dual_adc_sched_chk #(.STAGGER(STAGGER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .comb_active (comb_active),
  .start_m     (start_m),
  .start_s     (start_s),
  .grp_m       (grp_m),
  .grp_s       (grp_s),
  .abort_m     (abort_m),
  .abort_s     (abort_s),
  .done_m      (done_m),
  .done_s      (done_s),
  .clr_reg     (clr_reg),
  .clr_pre     (clr_pre),
  .cmpl_reg    (cmpl_reg),
  .cmpl_pre    (cmpl_pre)
);

// File: tb/dual_adc_sched_bench.sv
module dual_adc_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAGGER    = 14;
  localparam logic [3:0] COMB = 4'd6;
  localparam logic [3:0] INDEP = 4'd0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_sel = COMB;
  logic       reg_trig_m = 0, pre_trig_m = 0, reg_trig_s = 0, pre_trig_s = 0;
  logic       done_m = 0, done_s = 0;
  logic [1:0] clr_reg = 0, clr_pre = 0;
  logic       start_m, start_s, grp_m, grp_s, abort_m, abort_s;
  logic [1:0] cmpl_reg, cmpl_pre;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_adc_sched #(.STAGGER(STAGGER), .MODE_W(4), .COMB_CODE(COMB)) u_dual_adc_sched (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .reg_trig_m(reg_trig_m), .pre_trig_m(pre_trig_m),
    .reg_trig_s(reg_trig_s), .pre_trig_s(pre_trig_s),
    .done_m(done_m), .done_s(done_s), .clr_reg(clr_reg), .clr_pre(clr_pre),
    .start_m(start_m), .start_s(start_s), .grp_m(grp_m), .grp_s(grp_s),
    .abort_m(abort_m), .abort_s(abort_s), .cmpl_reg(cmpl_reg), .cmpl_pre(cmpl_pre)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Returns the number of cycles until the chosen start strobe, or -1.
  task automatic wait_start(input bit slave, input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (slave ? start_s : start_m) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic done_both();
    done_m = 1; done_s = 1; step(); done_m = 0; done_s = 0;
  endtask

  task automatic clear_all();
    clr_reg = 2'b11; clr_pre = 2'b11; step(); clr_reg = 0; clr_pre = 0;
  endtask

  task automatic t_reset();
    chk("R1", "start_m", start_m, 0);
    chk("R1", "start_s", start_s, 0);
    chk("R1", "aborts", {abort_m, abort_s}, 0);
    chk("R1", "cmpl_reg", cmpl_reg, 0);
    chk("R1", "cmpl_pre", cmpl_pre, 0);
  endtask

  task automatic t_stagger();
    int k;
    reg_trig_m = 1; step(); reg_trig_m = 0;
    chk("R2", "master start", start_m, 1);
    chk("R2", "master tag", grp_m, 0);
    chk("R2", "slave not yet", start_s, 0);
    wait_start(1, 30, k);
    chk("R2", "stagger cycles", k, STAGGER);
    chk("R2", "slave tag", grp_s, 0);
    reg_trig_m = 1; step(); reg_trig_m = 0;
    chk("R7", "regular during pair ignored", {start_m, start_s}, 0);
    done_m = 1; step(); done_m = 0;
    chk("R8", "master flag alone", cmpl_reg, 2'b01);
    step(3);
    done_s = 1; step(); done_s = 0;
    chk("R8", "both regular flags", cmpl_reg, 2'b11);
    chk("R8", "no preempted flag", cmpl_pre, 0);
    clr_reg = 2'b11; step(); clr_reg = 0;
    chk("R9", "cleared by write", cmpl_reg, 0);
    step(2);
  endtask

  task automatic t_pre_basic();
    int k;
    pre_trig_m = 1; step(); pre_trig_m = 0;
    chk("R3", "both start", {start_m, start_s}, 2'b11);
    chk("R3", "both tags", {grp_m, grp_s}, 2'b11);
    chk("R3", "no abort", {abort_m, abort_s}, 0);
    step();
    pre_trig_m = 1; reg_trig_m = 1; step(); pre_trig_m = 0; reg_trig_m = 0;
    chk("R6", "second preempt ignored", {start_m, start_s}, 0);
    step(2);
    chk("R6", "still no start", {start_m, start_s}, 0);
    done_both();
    chk("R8", "preempted flags", cmpl_pre, 2'b11);
    step();
    chk("R7", "held regular, master first", start_m, 1);
    chk("R7", "master tag regular", grp_m, 0);
    chk("R7", "slave waits", start_s, 0);
    wait_start(1, 30, k);
    chk("R7", "held pair stagger", k, STAGGER);
    done_both();
    chk("R8", "regular flags", cmpl_reg, 2'b11);
    clear_all();
    chk("R9", "all cleared", {cmpl_reg, cmpl_pre}, 0);
    step(2);
  endtask

  task automatic t_abort_resume();
    int k;
    int seen;
    reg_trig_m = 1; step(); reg_trig_m = 0;
    chk("R2", "master start", start_m, 1);
    step(4);
    pre_trig_m = 1; step(); pre_trig_m = 0;
    chk("R4", "abort master", abort_m, 1);
    chk("R4", "slave idle no abort", abort_s, 0);
    chk("R4", "preempted starts", {start_m, start_s, grp_m, grp_s}, 4'b1111);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (start_m || start_s) seen++;
    end
    chk("R4", "owed slave start cancelled", seen, 0);
    chk("R4", "aborted sets no flag", cmpl_reg, 0);
    done_both();
    chk("R8", "preempted flags", cmpl_pre, 2'b11);
    step();
    chk("R5", "slave resumes first", start_s, 1);
    chk("R5", "slave tag regular", grp_s, 0);
    chk("R5", "master waits", start_m, 0);
    wait_start(0, 30, k);
    chk("R5", "resume stagger", k, STAGGER);
    step(2);
    pre_trig_m = 1; step(); pre_trig_m = 0;
    chk("R4", "both aborted", {abort_m, abort_s}, 2'b11);
    done_both();
    step();
    chk("R5", "second resume slave first", {start_s, start_m}, 2'b10);
    wait_start(0, 30, k);
    chk("R5", "second resume stagger", k, STAGGER);
    done_both();
    chk("R8", "resumed pair flags", cmpl_reg, 2'b11);
    clear_all();
    step(2);
  endtask

  task automatic t_sticky();
    int k;
    done_m = 1; step(); done_m = 0;
    chk("R8", "idle done ignored", {cmpl_reg, cmpl_pre}, 0);
    reg_trig_m = 1; step(); reg_trig_m = 0;
    step(2);
    done_m = 1; clr_reg = 2'b01; step(); done_m = 0; clr_reg = 0;
    chk("R9", "set wins over clear", cmpl_reg[0], 1);
    step(3);
    chk("R9", "flag holds", cmpl_reg[0], 1);
    clr_reg = 2'b01; step(); clr_reg = 0;
    chk("R9", "flag cleared", cmpl_reg[0], 0);
    wait_start(1, 30, k);
    done_s = 1; step(); done_s = 0;
    chk("R8", "slave flag only", cmpl_reg, 2'b10);
    clear_all();
    step(2);
  endtask

  task automatic t_indep();
    int seen;
    mode_sel = INDEP; step(2);
    reg_trig_s = 1; step(); reg_trig_s = 0;
    chk("R10", "slave own regular", {start_s, start_m, grp_s}, 3'b100);
    seen = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (start_m) seen++;
    end
    chk("R10", "no master start", seen, 0);
    pre_trig_m = 1; step(); pre_trig_m = 0;
    chk("R10", "master own preempt", {start_m, grp_m, start_s}, 3'b110);
    done_both();
    chk("R10", "regular flag slave", cmpl_reg, 2'b10);
    chk("R10", "preempted flag master", cmpl_pre, 2'b01);
    clear_all();
    step(2);
    mode_sel = COMB; step(2);
    reg_trig_s = 1; pre_trig_s = 1; step(); reg_trig_s = 0; pre_trig_s = 0;
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (start_m || start_s) seen++;
      step();
    end
    chk("R10", "slave triggers ignored in combined", seen, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    step(2);
    t_stagger();
    t_pre_basic();
    t_abort_resume();
    t_sticky();
    t_indep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule